// File: doc/BRIEF.md
# Deep-Sleep Stop Mode Sequencer

This block decides when a core's wait request becomes a Stop-mode entry and brings the system back out of Stop. A wait-for-interrupt or wait-for-event strobe, or a return-from-handler strobe when sleep-on-exit is configured, starts an entry attempt. The attempt is only accepted when deep sleep is configured and power-down select is clear.

The attempt passes through a one-cycle check. If any pending flag relevant to the request is set, the attempt is dropped silently and the core keeps running; a one-cycle abort pulse marks the refusal. Once in Stop, the core clock is gated and the regulator may be asked to go to low power.

A wakeup interrupt or wakeup event line leaves Stop. Wakeup forces the system clock select to the internal RC oscillator. It then holds the clocks off for a startup delay whose length depends on the regulator mode latched at entry.

Top module: `stop_seq_top`

## Requirements
- R1: With `cfg_deep`=1 and `cfg_pdsel`=0, a `wfi_req` or `wfe_req` strobe seen in the running state causes a check on the next clock edge. If nothing blocks the request, `stop_active` is 1 and `core_clk_en` is 0 from that edge on.
- R2: If `cfg_deep`=0 or `cfg_pdsel`=1, entry strobes have no effect: `core_clk_en` stays 1, `stop_active` stays 0 and no `entry_aborted` pulse appears.
- R3: A wait-for-interrupt or return-from-handler request is blocked by any bit of `irq_pend`, any bit of `flag_pend`, or `wake_irq`/`wake_evt` being high at the check edge. Bits of `evt_pend` do not block it.
- R4: A wait-for-event request (`wfe_req`=1) is blocked by every source listed in R3 and, in addition, by any bit of `evt_pend`.
- R5: A blocked request raises `entry_aborted` for exactly one cycle after the check edge. The block returns to running and `core_clk_en` stays 1.
- R6: `handler_ret` starts entry only when `cfg_sleep_exit`=1, with the same configuration condition as R1. It has no effect when `cfg_sleep_exit`=0.
- R7: `reg_lp_req` is 1 during Stop exactly when `cfg_lpreg` was 1 at the request edge, and it is 0 outside Stop.
- R8: In Stop, a high `wake_irq` or `wake_evt` ends Stop. `core_clk_en` then stays 0 for `LP_WAKE_CYC` further cycles if the regulator was in low power, or for `ON_WAKE_CYC` cycles if it was not, and becomes 1 after that.
- R9: Wakeup forces `sys_clk_sel` to 0 (0 means the internal RC oscillator, 1 means the external source). In the running state, a `clk_sel_wr` strobe loads `clk_sel_val` into `sys_clk_sel`.
- R10: After `rst_n` is low at a clock edge, the block is running with `core_clk_en`=1, `sys_clk_sel`=0, and `stop_active`, `reg_lp_req` and `entry_aborted` all 0.
- R11: While in Stop, pending flags and entry strobes have no effect; only the wakeup lines end Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt strobe |
| wfe_req | input | 1 | Wait-for-event strobe |
| handler_ret | input | 1 | Return-from-handler strobe |
| cfg_deep | input | 1 | Deep-sleep configuration bit |
| cfg_pdsel | input | 1 | Power-down select; 1 forbids Stop entry |
| cfg_lpreg | input | 1 | 1 selects low-power regulator during Stop |
| cfg_sleep_exit | input | 1 | Sleep-on-exit enable |
| irq_pend | input | IRQ_W | Pending interrupt bits (external lines and peripherals) |
| evt_pend | input | EVT_W | Pending event bits |
| flag_pend | input | FLAG_W | Alarm, wakeup-timer, tamper and timestamp flags |
| wake_irq | input | 1 | Wakeup interrupt line |
| wake_evt | input | 1 | Wakeup event line |
| clk_sel_wr | input | 1 | Clock-select write strobe |
| clk_sel_val | input | 1 | Clock-select write value |
| core_clk_en | output | 1 | Core clock enable |
| reg_lp_req | output | 1 | Regulator low-power request |
| sys_clk_sel | output | 1 | System clock source (0 = internal RC) |
| stop_active | output | 1 | High while in Stop |
| entry_aborted | output | 1 | One-cycle pulse on a refused entry |

## Verification
On every cycle, the assertions check the following:
- the core clock is off while in Stop;
- the regulator request appears only in Stop;
- Stop holds until a wakeup line rises;
- the clock select reads the internal RC oscillator as Stop ends;
- the abort flag is a single-cycle pulse;
- Stop is only entered when no blocking flag was set at the check edge.

Some behaviour only the bench scenarios can show, because it needs expected values built from the configuration:
- which pending vector blocks which kind of request;
- that disallowed configurations leave the core running;
- that sleep-on-exit gates the handler return;
- the exact length of the wake delay for each regulator mode.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
   typedef enum logic [1:0] {
      ST_RUN         = 2'd0,
      ST_ENTER_CHECK = 2'd1,
      ST_STOP        = 2'd2,
      ST_WAKE_DELAY  = 2'd3
   } seq_state_e;

   function automatic int unsigned cnt_bits(input int unsigned val);
      int unsigned w;
      w = 1;
      while ((32'd1 << w) <= val) w++;
      return w;
   endfunction
endpackage

// File: rtl/stop_seq_gate.sv
// Combinational blocking decision for one entry attempt.
module stop_seq_gate #(
   parameter int unsigned IRQ_W  = 8,
   parameter int unsigned EVT_W  = 4,
   parameter int unsigned FLAG_W = 6
) (
   input  logic              req_is_evt,
   input  logic [IRQ_W-1:0]  irq_pend,
   input  logic [EVT_W-1:0]  evt_pend,
   input  logic [FLAG_W-1:0] flag_pend,
   input  logic              wake_irq,
   input  logic              wake_evt,
   output logic              blocked
);
   logic any_irq, any_evt, any_flag, any_wake;

   always_comb begin
      any_irq  = |irq_pend;
      any_evt  = |evt_pend;
      any_flag = |flag_pend;
      any_wake = wake_irq | wake_evt;
      blocked  = any_irq | any_flag | any_wake | (req_is_evt & any_evt);
   end
endmodule

// File: rtl/stop_seq_wake_timer.sv
// Down-counter timing the startup delay after a wakeup.
module stop_seq_wake_timer #(
   parameter int unsigned LP_CYC = 16,
   parameter int unsigned ON_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic lp_sel,
   output logic done
);
   localparam int unsigned MAX_CYC = (LP_CYC > ON_CYC) ? LP_CYC : ON_CYC;
   localparam int unsigned CW      = stop_seq_pkg::cnt_bits(MAX_CYC);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_val;

   generate
      if (LP_CYC == ON_CYC) begin : g_same
         logic unused_sel;
         assign unused_sel = lp_sel;
         assign load_val   = CW'(LP_CYC - 1);
      end else begin : g_split
         assign load_val = lp_sel ? CW'(LP_CYC - 1) : CW'(ON_CYC - 1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/stop_seq_clksel.sv
// System clock source register: forced to internal RC on wakeup.
module stop_seq_clksel (
   input  logic clk,
   input  logic rst_n,
   input  logic force_rc,
   input  logic wr_en,
   input  logic wr_val,
   output logic sel
);
   always_ff @(posedge clk) begin
      if (!rst_n)        sel <= 1'b0;
      else if (force_rc) sel <= 1'b0;
      else if (wr_en)    sel <= wr_val;
   end
endmodule

// File: rtl/stop_seq_top.sv
module stop_seq_top #(
   parameter int unsigned IRQ_W       = 8,
   parameter int unsigned EVT_W       = 4,
   parameter int unsigned FLAG_W      = 6,
   parameter int unsigned LP_WAKE_CYC = 16,
   parameter int unsigned ON_WAKE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wfi_req,
   input  logic              wfe_req,
   input  logic              handler_ret,
   input  logic              cfg_deep,
   input  logic              cfg_pdsel,
   input  logic              cfg_lpreg,
   input  logic              cfg_sleep_exit,
   input  logic [IRQ_W-1:0]  irq_pend,
   input  logic [EVT_W-1:0]  evt_pend,
   input  logic [FLAG_W-1:0] flag_pend,
   input  logic              wake_irq,
   input  logic              wake_evt,
   input  logic              clk_sel_wr,
   input  logic              clk_sel_val,
   output logic              core_clk_en,
   output logic              reg_lp_req,
   output logic              sys_clk_sel,
   output logic              stop_active,
   output logic              entry_aborted
);
   import stop_seq_pkg::*;

   generate
      if (LP_WAKE_CYC < 1 || ON_WAKE_CYC < 1) begin : g_bad_delay
         $error("stop_seq_top: wake delays must be at least one cycle");
      end
      if (IRQ_W < 1 || EVT_W < 1 || FLAG_W < 1) begin : g_bad_width
         $error("stop_seq_top: pending vectors need at least one bit");
      end
   endgenerate

   seq_state_e st_q, st_d;
   logic       req_evt_q, lp_q, abort_q;
   logic       blocked, timer_done, timer_load;
   logic       allow_cfg, want_wait, want_ret, want_entry;

   always_comb begin
      allow_cfg  = cfg_deep & ~cfg_pdsel;
      want_wait  = (wfi_req | wfe_req) & allow_cfg;
      want_ret   = handler_ret & cfg_sleep_exit & allow_cfg;
      want_entry = want_wait | want_ret;
   end

   stop_seq_gate #(.IRQ_W(IRQ_W), .EVT_W(EVT_W), .FLAG_W(FLAG_W)) gate_i (
      .req_is_evt (req_evt_q),
      .irq_pend   (irq_pend),
      .evt_pend   (evt_pend),
      .flag_pend  (flag_pend),
      .wake_irq   (wake_irq),
      .wake_evt   (wake_evt),
      .blocked    (blocked)
   );

   always_comb begin
      st_d       = st_q;
      timer_load = 1'b0;
      unique case (st_q)
         ST_RUN:         if (want_entry) st_d = ST_ENTER_CHECK;
         ST_ENTER_CHECK: st_d = blocked ? ST_RUN : ST_STOP;
         ST_STOP: begin
            if (wake_irq | wake_evt) begin
               st_d       = ST_WAKE_DELAY;
               timer_load = 1'b1;
            end
         end
         ST_WAKE_DELAY:  if (timer_done) st_d = ST_RUN;
         default:        st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_RUN;
         req_evt_q <= 1'b0;
         lp_q      <= 1'b0;
         abort_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         abort_q <= (st_q == ST_ENTER_CHECK) & blocked;
         if (st_q == ST_RUN && want_entry) begin
            req_evt_q <= wfe_req;
            lp_q      <= cfg_lpreg;
         end
      end
   end

   stop_seq_wake_timer #(.LP_CYC(LP_WAKE_CYC), .ON_CYC(ON_WAKE_CYC)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (timer_load),
      .lp_sel (lp_q),
      .done   (timer_done)
   );

   stop_seq_clksel clksel_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_rc (timer_load),
      .wr_en    (clk_sel_wr && st_q == ST_RUN),
      .wr_val   (clk_sel_val),
      .sel      (sys_clk_sel)
   );

   always_comb begin
      stop_active   = (st_q == ST_STOP);
      core_clk_en   = !(st_q == ST_STOP || st_q == ST_WAKE_DELAY);
      reg_lp_req    = stop_active & lp_q;
      entry_aborted = abort_q;
   end
endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk #(
   parameter int unsigned IRQ_W  = 8,
   parameter int unsigned FLAG_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IRQ_W-1:0]  irq_pend,
   input logic [FLAG_W-1:0] flag_pend,
   input logic              wake_irq,
   input logic              wake_evt,
   input logic              core_clk_en,
   input logic              reg_lp_req,
   input logic              sys_clk_sel,
   input logic              stop_active,
   input logic              entry_aborted
);
   AST_CLK_OFF_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_active |-> !core_clk_en); // R8
   AST_LP_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      reg_lp_req |-> stop_active); // R7
   AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      entry_aborted |=> !entry_aborted); // R5
   AST_ABORT_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      entry_aborted |-> core_clk_en); // R5
   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && !wake_irq && !wake_evt) |=> stop_active); // R11
   AST_WAKE_RC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_active) |-> !sys_clk_sel); // R9
   AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_active) |-> $past(!(|irq_pend) && !(|flag_pend) && !wake_irq && !wake_evt)); // R3
endmodule

bind stop_seq_top stop_seq_chk #(.IRQ_W(IRQ_W), .FLAG_W(FLAG_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .irq_pend      (irq_pend),
   .flag_pend     (flag_pend),
   .wake_irq      (wake_irq),
   .wake_evt      (wake_evt),
   .core_clk_en   (core_clk_en),
   .reg_lp_req    (reg_lp_req),
   .sys_clk_sel   (sys_clk_sel),
   .stop_active   (stop_active),
   .entry_aborted (entry_aborted)
);

// File: tb/stop_seq_tb.sv
module stop_seq_top_tb_top;
   localparam int unsigned IRQ_W = 8, EVT_W = 4, FLAG_W = 6;
   localparam int unsigned LPD = 16, OND = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi_req = 0, wfe_req = 0, handler_ret = 0;
   logic cfg_deep = 0, cfg_pdsel = 0, cfg_lpreg = 0, cfg_sleep_exit = 0;
   logic [IRQ_W-1:0]  irq_pend = '0;
   logic [EVT_W-1:0]  evt_pend = '0;
   logic [FLAG_W-1:0] flag_pend = '0;
   logic wake_irq = 0, wake_evt = 0, clk_sel_wr = 0, clk_sel_val = 0;
   logic core_clk_en, reg_lp_req, sys_clk_sel, stop_active, entry_aborted;

   int total = 0;
   int bad = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   stop_seq_top #(.IRQ_W(IRQ_W), .EVT_W(EVT_W), .FLAG_W(FLAG_W),
                  .LP_WAKE_CYC(LPD), .ON_WAKE_CYC(OND)) dut_i (
      .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
      .handler_ret(handler_ret), .cfg_deep(cfg_deep), .cfg_pdsel(cfg_pdsel),
      .cfg_lpreg(cfg_lpreg), .cfg_sleep_exit(cfg_sleep_exit),
      .irq_pend(irq_pend), .evt_pend(evt_pend), .flag_pend(flag_pend),
      .wake_irq(wake_irq), .wake_evt(wake_evt), .clk_sel_wr(clk_sel_wr),
      .clk_sel_val(clk_sel_val), .core_clk_en(core_clk_en),
      .reg_lp_req(reg_lp_req), .sys_clk_sel(sys_clk_sel),
      .stop_active(stop_active), .entry_aborted(entry_aborted));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit f_qual(input int kind, input bit deep, input bit pds, input bit sx);
      if (!deep || pds) return 1'b0;
      if (kind == 2) return sx;
      return 1'b1;
   endfunction

   function automatic bit f_block(input int kind, input logic [IRQ_W-1:0] ir,
                                  input logic [EVT_W-1:0] ev, input logic [FLAG_W-1:0] fl,
                                  input bit wk);
      return (ir != 0) || (fl != 0) || wk || (kind == 1 && ev != 0);
   endfunction

   // kind: 0 wait-for-interrupt, 1 wait-for-event, 2 handler return
   task automatic try_enter(input int kind, input bit deep, input bit pds, input bit sx,
                            input bit lp, input logic [IRQ_W-1:0] ir,
                            input logic [EVT_W-1:0] ev, input logic [FLAG_W-1:0] fl,
                            input bit wk, input string tag, output bit entered);
      bit q, b;
      q = f_qual(kind, deep, pds, sx);
      b = f_block(kind, ir, ev, fl, wk);
      cfg_deep = deep; cfg_pdsel = pds; cfg_sleep_exit = sx; cfg_lpreg = lp;
      wfi_req = (kind == 0); wfe_req = (kind == 1); handler_ret = (kind == 2);
      irq_pend = ir; evt_pend = ev; flag_pend = fl; wake_irq = wk;
      @(negedge clk);
      wfi_req = 0; wfe_req = 0; handler_ret = 0;
      @(negedge clk);
      entered = q && !b;
      chk(stop_active == entered, {tag, " stop_active"}, stop_active, entered);
      chk(core_clk_en == !entered, {tag, " core_clk_en"}, core_clk_en, !entered);
      chk(entry_aborted == (q && b), {tag, " entry_aborted (R5)"}, entry_aborted, q && b);
      chk(reg_lp_req == (entered && lp), {tag, " reg_lp_req (R7)"}, reg_lp_req, entered && lp);
      irq_pend = '0; evt_pend = '0; flag_pend = '0; wake_irq = 0;
      @(negedge clk);
      chk(entry_aborted == 1'b0, "R5 pulse one cycle", entry_aborted, 0);
      chk(stop_active == entered, {tag, " state held"}, stop_active, entered);
   endtask

   task automatic do_wake(input bit use_evt, input bit lp);
      int n = 0;
      if (use_evt) wake_evt = 1; else wake_irq = 1;
      @(negedge clk);
      wake_evt = 0; wake_irq = 0;
      while (!core_clk_en && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk(n == (lp ? LPD : OND), "R8 wake delay", n, lp ? LPD : OND);
      chk(sys_clk_sel == 1'b0, "R9 clk forced to RC", sys_clk_sel, 0);
      chk(stop_active == 1'b0 && reg_lp_req == 1'b0, "R7 after wake", reg_lp_req, 0);
   endtask

   task automatic write_sel(input bit v);
      clk_sel_wr = 1; clk_sel_val = v;
      @(negedge clk);
      clk_sel_wr = 0;
      chk(sys_clk_sel == v, "R9 clk select write", sys_clk_sel, v);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         report();
      end
   end

   initial begin
      bit ent;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(core_clk_en == 1 && stop_active == 0 && reg_lp_req == 0 &&
          sys_clk_sel == 0 && entry_aborted == 0, "R10 reset state",
          {core_clk_en, stop_active, reg_lp_req, sys_clk_sel, entry_aborted}, 5'b10000);
      rst_n = 1;
      @(negedge clk);

      // R1 clean wfi entry with low-power regulator, R8 long delay
      write_sel(1);
      try_enter(0, 1, 0, 0, 1, '0, '0, '0, 0, "R1 wfi clean", ent);
      // R11 strobes and pending flags in Stop
      irq_pend = 8'h81; flag_pend = 6'h3; wfe_req = 1; handler_ret = 1;
      repeat (3) @(negedge clk);
      chk(stop_active == 1, "R11 stays in Stop", stop_active, 1);
      irq_pend = '0; flag_pend = '0; wfe_req = 0; handler_ret = 0;
      do_wake(0, 1);
      // R4 wfe blocked by event pending
      try_enter(1, 1, 0, 0, 0, '0, 4'h2, '0, 0, "R4 wfe evt pending", ent);
      // R3 wfi not blocked by event pending, regulator on
      try_enter(0, 1, 0, 0, 0, '0, 4'h8, '0, 0, "R3 wfi ignores evt", ent);
      do_wake(1, 0);
      // R3 flag blocks, wake line blocks
      try_enter(0, 1, 0, 0, 0, '0, '0, 6'h20, 0, "R3 flag blocks", ent);
      try_enter(0, 1, 0, 0, 0, '0, '0, '0, 1, "R3 wake in check", ent);
      try_enter(1, 1, 0, 0, 0, 8'h10, '0, '0, 0, "R4 irq blocks wfe", ent);
      // R2 bad configuration
      try_enter(0, 1, 1, 0, 0, '0, '0, '0, 0, "R2 pdsel set", ent);
      try_enter(1, 0, 0, 0, 0, '0, '0, '0, 0, "R2 deep clear", ent);
      // R6 handler return
      try_enter(2, 1, 0, 0, 0, '0, '0, '0, 0, "R6 no sleep-exit", ent);
      try_enter(2, 1, 0, 1, 0, '0, '0, '0, 0, "R6 sleep-exit", ent);
      if (ent) do_wake(0, 0);

      // constrained random
      for (int i = 0; i < 80; i++) begin
         int kind;
         bit deep, pds, sx, lp, wk;
         logic [IRQ_W-1:0] ir;
         logic [EVT_W-1:0] ev;
         logic [FLAG_W-1:0] fl;
         kind = int'($urandom % 3);
         deep = ($urandom % 4) != 0;
         pds  = ($urandom % 4) == 0;
         sx   = $urandom % 2;
         lp   = $urandom % 2;
         ir   = (($urandom % 4) == 0) ? IRQ_W'(1) << ($urandom % IRQ_W) : '0;
         ev   = (($urandom % 3) == 0) ? EVT_W'(1) << ($urandom % EVT_W) : '0;
         fl   = (($urandom % 5) == 0) ? FLAG_W'(1) << ($urandom % FLAG_W) : '0;
         wk   = ($urandom % 8) == 0;
         write_sel($urandom % 2);
         try_enter(kind, deep, pds, sx, lp, ir, ev, fl, wk, "R1 random", ent);
         if (ent) begin
            int idle = int'($urandom % 4);
            for (int j = 0; j < idle; j++) begin
               irq_pend = IRQ_W'($urandom); evt_pend = EVT_W'($urandom);
               wfi_req = $urandom % 2;
               @(negedge clk);
            end
            irq_pend = '0; evt_pend = '0; wfi_req = 0;
            chk(stop_active == 1, "R11 random stays", stop_active, 1);
            do_wake($urandom % 2, lp);
         end
      end
      done_flag = 1;
      report();
   end
endmodule